// File: doc/BRIEF.md
# Partial Reconfiguration Mailbox Controller

This block lets a host push a partial-reconfiguration bitstream, one 32-bit word at a time, to a device configuration manager. The host sees four registers and an interrupt. The controller opens each operation by sending a command over a command/response mailbox. It waits for each reply. It forwards bitstream words only while the exchange is in its streaming stage. When the host marks the end of the bitstream, the controller closes the operation with a status query.

The controller keeps a readable handshake-stage value. The host can use it to match the captured 32-bit reply word to the command that produced it. When an operation fails, the stage keeps the last position reached. The ready signal toward the bitstream source drops, and an interrupt reports the end of the operation.

Top module: `pr_mbox_ctrl`

## Requirements
- R1: After reset, the status field is 3'b000 (idle), the handshake stage is 0, the response register is 0, and both `irq_o` and `bs_ready_o` are low.
- R2: A write to address 0x1 with bit 0 set starts an operation when the status is not in progress. One cycle later the status field, bits [3:1] of the control/status register, reads 3'b010. Writing 0x21 therefore reads back as 0x24. In that same cycle a one-cycle command pulse carries code 0 (start) and the stage reads 1.
- R3: The stage register at address 0x3 has these values:
  - 1: start command sent.
  - 2: start reply received.
  - 3: status query sent.
  - 4: query reply received.
  - 5: start from the selected source sent.
  - 6: that reply received.

  An error-free reply moves an odd stage to the next even stage. With bit 6 set in the start write, command code 2 is used. The stage then reads 5, 6 for one cycle, then 3 with command code 1.
- R4: `bs_ready_o` is high only while the operation is in progress at stage 2 and `mb_data_ready_i` is high. A write to address 0x0 is forwarded on `mb_data_valid_o`/`mb_data_o` in the same cycle only under that condition. At any other time it is ignored.
- R5: A control write with bit 4 set at stage 2 sends command code 1 and moves the stage to 3. An error-free reply to it sets the status to 3'b011 (success) and the stage to 4.
- R6: A reply whose bits [7:0] are nonzero, whether awaited or unsolicited, sets the status to 3'b100. The stage keeps its last value and `bs_ready_o` drops.
- R7: If an awaited reply has not arrived within TIMEOUT (1024) cycles of the command, the status becomes 3'b100 and the stage keeps its odd value.
- R8: Address 0x4 returns the last reply word received during the operation. It holds that value after the operation ends and clears to 0 at the next accepted start.
- R9: When an operation ends, an interrupt-pending flag sets; it reads as bit 4 of the control/status register. `irq_o` is that flag gated by the enable bit 5, which every control write loads. A read of address 0x1 clears the pending flag.
- R10: A start write while the status is in progress changes neither the stage nor the command outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears pending interrupt on 0x1) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Write data; bitstream word at 0x0 |
| reg_rdata_o | output | 32 | Read data for the addressed register, combinational |
| irq_o | output | 1 | Interrupt |
| bs_ready_o | output | 1 | Bitstream words are accepted |
| mb_cmd_valid_o | output | 1 | One-cycle mailbox command pulse |
| mb_cmd_code_o | output | 2 | Command: 0 start, 1 status query, 2 start from selected source |
| mb_data_valid_o | output | 1 | Bitstream word valid toward the manager |
| mb_data_o | output | 32 | Bitstream word |
| mb_data_ready_i | input | 1 | Manager can take a word |
| mb_rsp_valid_i | input | 1 | Reply word valid |
| mb_rsp_data_i | input | 32 | Reply word; bits [7:0] are the error code |

## Verification
The register read data, the data-valid output and `bs_ready_o` are combinational. They are sampled half a cycle after the inputs are driven, before the next edge. Status, stage, response, the command pulse and the interrupt are registered and change at the edge that samples the stimulus. They are read in the following cycle, so a start shows 0x24 together with the command pulse one cycle later. The timeout is checked at exactly its edge: still in progress 1024 negedges after the start edge, in error one negedge later. A behavioural model in the bench advances on every rising edge and is compared on every falling edge.

// File: rtl/pr_mbox_pkg.sv
`timescale 1ns/1ps
package pr_mbox_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'b000,
    ST_BUSY = 3'b010,
    ST_OK   = 3'b011,
    ST_ERR  = 3'b100
  } status_e;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_QUERY = 2'd1,
    CMD_SRC   = 2'd2
  } cmd_e;

  localparam logic [7:0] STG_NONE       = 8'd0;
  localparam logic [7:0] STG_START_SENT = 8'd1;
  localparam logic [7:0] STG_START_OK   = 8'd2;
  localparam logic [7:0] STG_QUERY_SENT = 8'd3;
  localparam logic [7:0] STG_QUERY_OK   = 8'd4;
  localparam logic [7:0] STG_SRC_SENT   = 8'd5;
  localparam logic [7:0] STG_SRC_OK     = 8'd6;

  localparam logic [2:0] A_DATA  = 3'd0;
  localparam logic [2:0] A_CSR   = 3'd1;
  localparam logic [2:0] A_STAGE = 3'd3;
  localparam logic [2:0] A_RSP   = 3'd4;

  localparam int B_START = 0;
  localparam int B_END   = 4;  // write side
  localparam int B_IRQ   = 4;  // read side
  localparam int B_IE    = 5;
  localparam int B_SRC   = 6;
endpackage

// File: rtl/pr_reply_timer.sv
`timescale 1ns/1ps
module pr_reply_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || expired_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pr_mbox_seq.sv
`timescale 1ns/1ps
module pr_mbox_seq
  import pr_mbox_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       src_sel_i,
  input  logic       end_i,
  input  logic       rsp_valid_i,
  input  logic       rsp_err_i,
  input  logic       timeout_i,
  output status_e    status_o,
  output logic [7:0] stage_o,
  output logic       cmd_valid_o,
  output cmd_e       cmd_code_o,
  output logic       streaming_o,
  output logic       waiting_o,
  output logic       busy_o,
  output logic       accept_o,
  output logic       done_o
);
  status_e    status_q, status_d;
  logic [7:0] stage_q, stage_d;
  logic       cmd_v_q, cmd_v_d;
  cmd_e       cmd_c_q, cmd_c_d;

  assign busy_o      = (status_q == ST_BUSY);
  assign accept_o    = start_i && !busy_o;
  assign waiting_o   = busy_o && stage_q[0];
  assign streaming_o = busy_o && (stage_q == STG_START_OK);

  always_comb begin
    status_d = status_q;
    stage_d  = stage_q;
    cmd_v_d  = 1'b0;
    cmd_c_d  = cmd_c_q;
    done_o   = 1'b0;
    if (accept_o) begin
      status_d = ST_BUSY;
      cmd_v_d  = 1'b1;
      if (src_sel_i) begin
        stage_d = STG_SRC_SENT;
        cmd_c_d = CMD_SRC;
      end else begin
        stage_d = STG_START_SENT;
        cmd_c_d = CMD_START;
      end
    end else if (busy_o) begin
      if ((waiting_o && timeout_i) || (rsp_valid_i && rsp_err_i)) begin
        status_d = ST_ERR;  // stage keeps last position
        done_o   = 1'b1;
      end else if (rsp_valid_i && waiting_o) begin
        stage_d = stage_q + 8'd1;
        if (stage_q == STG_QUERY_SENT) begin
          status_d = ST_OK;
          done_o   = 1'b1;
        end
      end else if (stage_q == STG_SRC_OK || (streaming_o && end_i)) begin
        stage_d = STG_QUERY_SENT;
        cmd_v_d = 1'b1;
        cmd_c_d = CMD_QUERY;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= ST_IDLE;
      stage_q  <= STG_NONE;
      cmd_v_q  <= 1'b0;
      cmd_c_q  <= CMD_START;
    end else begin
      status_q <= status_d;
      stage_q  <= stage_d;
      cmd_v_q  <= cmd_v_d;
      cmd_c_q  <= cmd_c_d;
    end
  end

  assign status_o    = status_q;
  assign stage_o     = stage_q;
  assign cmd_valid_o = cmd_v_q;
  assign cmd_code_o  = cmd_c_q;
endmodule

// File: rtl/pr_host_regs.sv
`timescale 1ns/1ps
module pr_host_regs
  import pr_mbox_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic          start_bit_i,
  input  logic          end_bit_i,
  input  logic          ie_bit_i,
  input  status_e       status_i,
  input  logic [7:0]    stage_i,
  input  logic          busy_i,
  input  logic          accept_i,
  input  logic          done_i,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_data_i,
  output logic          start_o,
  output logic          end_o,
  output logic          ie_o,
  output logic [DW-1:0] rsp_o,
  output logic          irq_o,
  output logic [DW-1:0] rdata_o
);
  logic          csr_sel;
  logic          ie_q, irq_q;
  logic [DW-1:0] rsp_q;

  assign csr_sel = (addr_i == AW'(A_CSR));
  assign start_o = wr_i && csr_sel && start_bit_i;
  assign end_o   = wr_i && csr_sel && end_bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= 1'b0;
      irq_q <= 1'b0;
      rsp_q <= '0;
    end else begin
      if (wr_i && csr_sel) ie_q <= ie_bit_i;
      if (done_i)                    irq_q <= 1'b1;
      else if (rd_i && csr_sel)      irq_q <= 1'b0;
      if (accept_i)                  rsp_q <= '0;
      else if (busy_i && rsp_valid_i) rsp_q <= rsp_data_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AW'(A_CSR): begin
        rdata_o[B_IE]  = ie_q;
        rdata_o[B_IRQ] = irq_q;
        rdata_o[3:1]   = status_i;
      end
      AW'(A_STAGE): rdata_o = DW'(stage_i);
      AW'(A_RSP):   rdata_o = rsp_q;
      default:      rdata_o = '0;
    endcase
  end

  assign ie_o  = ie_q;
  assign rsp_o = rsp_q;
  assign irq_o = irq_q && ie_q;
endmodule

// File: rtl/pr_mbox_ctrl.sv
`timescale 1ns/1ps
module pr_mbox_ctrl
  import pr_mbox_pkg::*;
#(
  parameter int DW      = 32,
  parameter int AW      = 3,
  parameter int ERR_W   = 8,
  parameter int TIMEOUT = 1024
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o,
  output logic          bs_ready_o,
  output logic          mb_cmd_valid_o,
  output logic [1:0]    mb_cmd_code_o,
  output logic          mb_data_valid_o,
  output logic [DW-1:0] mb_data_o,
  input  logic          mb_data_ready_i,
  input  logic          mb_rsp_valid_i,
  input  logic [DW-1:0] mb_rsp_data_i
);
  status_e       status_w;
  cmd_e          cmd_w;
  logic [7:0]    stage_w;
  logic          start_w, end_w, accept_w, done_w, busy_w;
  logic          streaming_w, waiting_w, timeout_w, rsp_err_w;
  logic          ie_w;
  logic [DW-1:0] rsp_w;

  assign rsp_err_w = |mb_rsp_data_i[ERR_W-1:0];

  pr_reply_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (waiting_w),
    .expired_o (timeout_w)
  );

  pr_mbox_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_w),
    .src_sel_i   (reg_wdata_i[B_SRC]),
    .end_i       (end_w),
    .rsp_valid_i (mb_rsp_valid_i),
    .rsp_err_i   (rsp_err_w),
    .timeout_i   (timeout_w),
    .status_o    (status_w),
    .stage_o     (stage_w),
    .cmd_valid_o (mb_cmd_valid_o),
    .cmd_code_o  (cmd_w),
    .streaming_o (streaming_w),
    .waiting_o   (waiting_w),
    .busy_o      (busy_w),
    .accept_o    (accept_w),
    .done_o      (done_w)
  );

  pr_host_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .rd_i        (reg_rd_i),
    .addr_i      (reg_addr_i),
    .start_bit_i (reg_wdata_i[B_START]),
    .end_bit_i   (reg_wdata_i[B_END]),
    .ie_bit_i    (reg_wdata_i[B_IE]),
    .status_i    (status_w),
    .stage_i     (stage_w),
    .busy_i      (busy_w),
    .accept_i    (accept_w),
    .done_i      (done_w),
    .rsp_valid_i (mb_rsp_valid_i),
    .rsp_data_i  (mb_rsp_data_i),
    .start_o     (start_w),
    .end_o       (end_w),
    .ie_o        (ie_w),
    .rsp_o       (rsp_w),
    .irq_o       (irq_o),
    .rdata_o     (reg_rdata_o)
  );

  assign mb_cmd_code_o   = cmd_w;
  assign bs_ready_o      = streaming_w && mb_data_ready_i;
  assign mb_data_valid_o = reg_wr_i && (reg_addr_i == AW'(A_DATA)) && bs_ready_o;
  assign mb_data_o       = reg_wdata_i;
endmodule

// File: rtl/pr_mbox_ctrl_chk.sv
`timescale 1ns/1ps
module pr_mbox_ctrl_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    status_i,
  input logic [7:0]    stage_i,
  input logic          accept_i,
  input logic          cmd_valid_i,
  input logic          ready_i,
  input logic          data_valid_i,
  input logic          irq_i,
  input logic          ie_i,
  input logic [DW-1:0] rsp_i
);
  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> (status_i == 3'b010) && cmd_valid_i && (stage_i == 8'd1 || stage_i == 8'd5));

  p_cmd_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> !cmd_valid_i);

  p_ready_stage_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |-> (status_i == 3'b010) && (stage_i == 8'd2));

  p_fwd_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_i |-> ready_i);

  p_busy_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == 3'b010) |=> (status_i == 3'b010 || status_i == 3'b011 || status_i == 3'b100));

  p_err_noready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == 3'b100) |-> !ready_i);

  p_stage_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i != 3'b010 && !accept_i) |=> $stable(stage_i));

  p_rsp_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i != 3'b010 && !accept_i) |=> $stable(rsp_i));

  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> ie_i);
endmodule

bind pr_mbox_ctrl pr_mbox_ctrl_chk #(.DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .status_i     (status_w),
  .stage_i      (stage_w),
  .accept_i     (accept_w),
  .cmd_valid_i  (mb_cmd_valid_o),
  .ready_i      (bs_ready_o),
  .data_valid_i (mb_data_valid_o),
  .irq_i        (irq_o),
  .ie_i         (ie_w),
  .rsp_i        (rsp_w)
);

// File: tb/pr_mbox_ctrl_test.sv
`timescale 1ns/1ps
module pr_mbox_ctrl_test;
  localparam int TO = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic        mb_ready = 1'b0, rspv = 1'b0;
  logic [31:0] rspd = '0;
  logic [31:0] rdata, mb_data;
  logic        irq, ready, cmdv, dv;
  logic [1:0]  cmdc;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pr_mbox_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .bs_ready_o(ready),
    .mb_cmd_valid_o(cmdv), .mb_cmd_code_o(cmdc),
    .mb_data_valid_o(dv), .mb_data_o(mb_data), .mb_data_ready_i(mb_ready),
    .mb_rsp_valid_i(rspv), .mb_rsp_data_i(rspd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int          m_status, m_stage, m_tmr, m_cmdc;
  logic [31:0] m_rsp;
  bit          m_irq, m_ie, m_cmdv;
  bit          t_csrw, t_st, t_en, t_busy, t_wt, t_tmo, t_dn, t_cv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_status = 0; m_stage = 0; m_tmr = 0; m_cmdc = 0;
      m_rsp = '0; m_irq = 0; m_ie = 0; m_cmdv = 0;
    end else begin
      t_csrw = wr && addr == 3'd1;
      t_st   = t_csrw && wdata[0];
      t_en   = t_csrw && wdata[4];
      t_busy = (m_status == 2);
      t_wt   = t_busy && (m_stage % 2 == 1);
      t_tmo  = t_wt && (m_tmr == TO - 1);
      m_tmr  = (t_wt && !t_tmo) ? m_tmr + 1 : 0;
      t_dn = 0; t_cv = 0;
      if (t_busy && rspv) m_rsp = rspd;
      if (t_st && !t_busy) begin
        m_rsp = '0; m_status = 2; t_cv = 1;
        if (wdata[6]) begin m_stage = 5; m_cmdc = 2; end
        else begin m_stage = 1; m_cmdc = 0; end
      end else if (t_busy) begin
        if (t_tmo || (rspv && rspd[7:0] != 0)) begin m_status = 4; t_dn = 1; end
        else if (rspv && t_wt) begin
          if (m_stage == 3) begin m_status = 3; t_dn = 1; end
          m_stage = m_stage + 1;
        end else if (m_stage == 6 || (m_stage == 2 && t_en)) begin
          m_stage = 3; m_cmdc = 1; t_cv = 1;
        end
      end
      m_cmdv = t_cv;
      if (t_dn) m_irq = 1;
      else if (rd && addr == 3'd1) m_irq = 0;
      if (t_csrw) m_ie = wdata[5];
    end
  end

  function automatic logic [31:0] exp_rdata();
    case (addr)
      3'd1: return {25'd0, 1'b0, m_ie, m_irq, 3'(m_status), 1'b0};
      3'd3: return 32'(m_stage);
      3'd4: return m_rsp;
      default: return 32'd0;
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 model rdata", rdata, exp_rdata());
      chk("R9 model irq", {31'd0, irq}, {31'd0, m_irq && m_ie});
      chk("R4 model ready", {31'd0, ready},
          {31'd0, m_status == 2 && m_stage == 2 && mb_ready});
      chk("R4 model data_valid", {31'd0, dv},
          {31'd0, wr && addr == 3'd0 && m_status == 2 && m_stage == 2 && mb_ready});
      chk("R2 model cmd_valid", {31'd0, cmdv}, {31'd0, m_cmdv});
      if (m_cmdv) chk("R2 model cmd_code", {30'd0, cmdc}, 32'(m_cmdc));
    end
  end

  task automatic idle(input logic [2:0] a);
    @(negedge clk); #1;
    wr = 0; rd = 0; rspv = 0; addr = a;
  endtask

  task automatic csr_write(input logic [31:0] v);
    @(negedge clk); #1;
    wr = 1; rd = 0; rspv = 0; addr = 3'd1; wdata = v;
  endtask

  task automatic data_write(input logic [31:0] v);
    @(negedge clk); #1;
    wr = 1; rd = 0; rspv = 0; addr = 3'd0; wdata = v;
    #0.5;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); #1;
    wr = 0; rd = 1; rspv = 0; addr = a;
    #0.5 v = rdata;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); #1;
    wr = 0; rd = 0; rspv = 0; addr = a;
    #0.5 v = rdata;
  endtask

  task automatic reply(input logic [31:0] v);
    @(negedge clk); #1;
    wr = 0; rd = 0; rspv = 1; rspd = v;
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    peek(3'd1, v); chk("R1 csr", v, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 ready", {31'd0, ready}, 32'd0);
    peek(3'd3, v); chk("R1 stage", v, 32'd0);
    peek(3'd4, v); chk("R1 rsp", v, 32'd0);

    // R4 data ignored while idle
    mb_ready = 1;
    data_write(32'hA5A5_0001);
    chk("R4 idle write dropped", {31'd0, dv}, 32'd0);

    // R2 start with interrupt enable
    csr_write(32'h21);
    reg_read(3'd1, v); chk("R2 csr readback", v, 32'h24);
    chk("R2 cmd pulse", {31'd0, cmdv}, 32'd1);
    chk("R2 cmd code start", {30'd0, cmdc}, 32'd0);
    peek(3'd3, v); chk("R2 stage after start", v, 32'd1);
    chk("R2 pulse ends", {31'd0, cmdv}, 32'd0);

    // R3 reply advances stage
    reply(32'h0000_1100);
    peek(3'd3, v); chk("R3 stage 2", v, 32'd2);
    chk("R4 ready streaming", {31'd0, ready}, 32'd1);

    // R10 start while busy ignored
    csr_write(32'h21);
    peek(3'd3, v); chk("R10 stage unchanged", v, 32'd2);
    chk("R10 no cmd pulse", {31'd0, cmdv}, 32'd0);

    // R4 streaming
    data_write(32'hDEAD_0010);
    chk("R4 forward valid", {31'd0, dv}, 32'd1);
    chk("R4 forward data", mb_data, 32'hDEAD_0010);
    data_write(32'hDEAD_0011);
    chk("R4 forward data 2", mb_data, 32'hDEAD_0011);
    mb_ready = 0;
    data_write(32'hDEAD_0012);
    chk("R4 no ready no forward", {31'd0, dv}, 32'd0);
    chk("R4 ready low", {31'd0, ready}, 32'd0);
    mb_ready = 1;

    // R5 end of bitstream, query, success
    csr_write(32'h30);
    peek(3'd3, v); chk("R5 stage 3", v, 32'd3);
    chk("R5 query code", {30'd0, cmdc}, 32'd1);
    reply(32'h0000_1200);
    peek(3'd3, v); chk("R5 stage 4", v, 32'd4);
    chk("R9 irq raised", {31'd0, irq}, 32'd1);
    reg_read(3'd1, v); chk("R5 success status", v, 32'h36);
    peek(3'd1, v); chk("R9 pending cleared", v, 32'h26);
    chk("R9 irq low", {31'd0, irq}, 32'd0);
    peek(3'd4, v); chk("R8 rsp captured", v, 32'h0000_1200);

    // R6 awaited reply with error
    csr_write(32'h21);
    peek(3'd4, v); chk("R8 rsp cleared on start", v, 32'd0);
    reply(32'h0000_0305);
    peek(3'd1, v); chk("R6 error status", v, 32'h38);
    peek(3'd3, v); chk("R6 stage held 1", v, 32'd1);
    peek(3'd4, v); chk("R8 error word", v, 32'h0000_0305);
    reg_read(3'd1, v);

    // R6 unsolicited error during streaming
    csr_write(32'h21);
    reply(32'h0);
    idle(3'd3);
    chk("R6 ready before error", {31'd0, ready}, 32'd1);
    reply(32'hBEEF_00AB);
    peek(3'd3, v); chk("R6 stage held 2", v, 32'd2);
    chk("R6 ready dropped", {31'd0, ready}, 32'd0);
    data_write(32'h1);
    chk("R6 no forward after error", {31'd0, dv}, 32'd0);
    peek(3'd4, v); chk("R8 rsp holds", v, 32'hBEEF_00AB);
    reg_read(3'd1, v);

    // R3 selected-source path
    csr_write(32'h61);
    peek(3'd3, v); chk("R3 stage 5", v, 32'd5);
    chk("R3 src code", {30'd0, cmdc}, 32'd2);
    reply(32'h0);
    peek(3'd3, v); chk("R3 stage 6", v, 32'd6);
    peek(3'd3, v); chk("R3 stage 3 after 6", v, 32'd3);
    chk("R3 query after src", {30'd0, cmdc}, 32'd1);
    reply(32'h0);
    peek(3'd1, v); chk("R3 src success", v, 32'h36);
    reg_read(3'd1, v);

    // R7 timeout, interrupt disabled
    csr_write(32'h01);
    idle(3'd1);
    repeat (1023) @(negedge clk);
    #0.5 chk("R7 still busy", rdata, 32'h04);
    @(negedge clk);
    #0.5 chk("R7 timed out", rdata, 32'h18);
    chk("R9 irq gated off", {31'd0, irq}, 32'd0);
    peek(3'd3, v); chk("R7 stage held", v, 32'd1);

    idle(3'd0);
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule